// File: doc/BRIEF.md
# UART FIFO Control and DMA-Ready Engine

This block is the FIFO front end of a 16550-style serial port. It contains a transmit byte queue and a receive byte queue, each 16 entries deep. A single control register sets the trigger level, the DMA signalling mode and the enable state, and it also accepts self-clearing flush commands. The host pushes bytes into the transmit queue and reads from the receive queue. The serial side pops transmit bytes and pushes received bytes. A receive timeout arrives as a one-cycle strobe from outside the block.

From the queue occupancy the block produces a receive trigger interrupt and two active-low DMA request pins, `txRdyN` and `rxRdyN`. In the first signalling mode these pins follow occupancy directly. In the second mode they switch with hysteresis. When the queues are disabled, each direction acts as a single-byte holding register.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the FIFOs are disabled, `ctrlRdData` reads 0x00, both counts are 0, `txRdyN` is 0, `rxRdyN` is 1 and `rxTrigIrq` is 0.
- R2: `ctrlRdData` reads back as {trigger select[7:6], 2'b00, dma select[3], 2'b00, enable[0]}. A control write whose bit 0 is 1 loads bits 7:6 and 3. A write whose bit 0 is 0 clears only the enable bit and leaves the other fields unchanged.
- R3: A control write with bits 0 and 2 both set empties the transmit queue on the next cycle and clears its overrun flag. The receive queue is not affected. A push in the same cycle is discarded.
- R4: A control write with bits 0 and 1 both set empties the receive queue on the next cycle and clears its overrun flag. A push in the same cycle is discarded.
- R5: A control write that changes the enable bit flushes both queues.
- R6: With the FIFOs enabled, each queue holds up to 16 bytes and returns them in first-in, first-out order. The count output reports the number of bytes held.
- R7: A push into a full queue is dropped and sets that direction's overrun flag. The flag stays set until that queue is flushed.
- R8: A pop from an empty queue leaves the read data output unchanged. Read data appears in the cycle after the pop strobe.
- R9: With the FIFOs disabled, each direction holds at most one byte.
- R10: With the FIFOs enabled, `rxTrigIrq` is high while the receive count is at least the trigger level. Trigger select 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With the FIFOs disabled, the interrupt is high while a byte is held.
- R11: Mode 0 applies when the FIFOs are disabled, or when they are enabled and dma select is 0. In mode 0, `txRdyN` is 1 exactly when the transmit count is nonzero, and `rxRdyN` is 0 exactly when the receive count is nonzero.
- R12: Mode 1 applies when the FIFOs are enabled and dma select is 1. In mode 1, `txRdyN` becomes 1 when the transmit queue is full, becomes 0 when it is empty, and otherwise holds its level.
- R13: In mode 1, `rxRdyN` becomes 0 when the receive count reaches the trigger level or when `rxTimeout` pulses while the queue is not empty. It returns to 1 only when the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control register write value |
| ctrlRdData | output | 8 | Control register readback |
| txWrEn | input | 1 | Host push into the transmit queue |
| txWrData | input | 8 | Byte to transmit |
| txPopEn | input | 1 | Serializer pop from the transmit queue |
| txPopData | output | 8 | Byte popped for transmission (valid one cycle after the pop) |
| txCount | output | 5 | Transmit occupancy |
| txOverrun | output | 1 | Sticky flag: a transmit push was dropped |
| rxPushEn | input | 1 | Deserializer push into the receive queue |
| rxPushData | input | 8 | Received byte |
| rxRdEn | input | 1 | Host pop from the receive queue |
| rxRdData | output | 8 | Byte read by the host (valid one cycle after the pop) |
| rxCount | output | 5 | Receive occupancy |
| rxOverrun | output | 1 | Sticky flag: a receive push was dropped |
| rxTimeout | input | 1 | Receive timeout strobe |
| rxTrigIrq | output | 1 | Receive trigger interrupt |
| txRdyN | output | 1 | Active-low transmit DMA request |
| rxRdyN | output | 1 | Active-low receive DMA request |

## Verification
A flush command and a data push can land on the same clock edge in the same direction. The bench provokes this by filling the receive queue partway, then raising `rxPushEn` in the very cycle of a control write that has bits 0 and 1 set. The same is done on the transmit side with bits 0 and 2. The result is judged by the count one cycle later: it must be zero, because the flush wins and the pushed byte is lost. In the transmit case, the receive count must also be unchanged.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Per-cycle commands from the control unit to the datapath
  typedef struct packed {
    logic txFlush;
    logic rxFlush;
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic legacy;   // FIFOs disabled: one-byte capacity
  } fifoStrobes_t;

  // Receive trigger threshold in characters
  function automatic int unsigned trigLevel(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         legacy,
  input  logic [W-1:0]                 wrData,
  output logic [W-1:0]                 rdData,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cap;
  logic          full, empty, doPush, doPop;

  assign cap    = legacy ? CW'(1) : CW'(DEPTH);
  assign full   = count >= cap;
  assign empty  = count == '0;
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
      rdData  <= '0;
    end else if (flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop) begin
        rdPtr  <= nextPtr(rdPtr);
        rdData <= mem[rdPtr];
      end
      if (push && full) overrun <= 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/uart_fifo_dp.sv
module uart_fifo_dp
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  fifoStrobes_t               stb,
  input  logic [7:0]                 txWrData,
  input  logic [7:0]                 rxPushData,
  output logic [7:0]                 txPopData,
  output logic [7:0]                 rxRdData,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic                       txOverrun,
  output logic                       rxOverrun
);
  uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) i_txq (
    .clk(clk), .rstN(rstN), .flush(stb.txFlush), .push(stb.txPush),
    .pop(stb.txPop), .legacy(stb.legacy), .wrData(txWrData),
    .rdData(txPopData), .count(txCount), .overrun(txOverrun));

  uart_byte_fifo #(.DEPTH(DEPTH), .W(8)) i_rxq (
    .clk(clk), .rstN(rstN), .flush(stb.rxFlush), .push(stb.rxPush),
    .pop(stb.rxPop), .legacy(stb.legacy), .wrData(rxPushData),
    .rdData(rxRdData), .count(rxCount), .overrun(rxOverrun));
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctrlWrEn,
  input  logic [7:0]                 ctrlWrData,
  input  logic                       txWrEn,
  input  logic                       txPopEn,
  input  logic                       rxPushEn,
  input  logic                       rxRdEn,
  input  logic                       rxTimeout,
  input  logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  output fifoStrobes_t               stb,
  output logic [7:0]                 ctrlRdData,
  output logic                       rxTrigIrq,
  output logic                       txRdyN,
  output logic                       rxRdyN
);
  localparam int CW = $clog2(DEPTH+1);

  logic       fifoEn, dmaSel;
  logic [1:0] trigSel;
  logic       wrOn, enFlip, mode1;
  logic       txEmpty, txFull, rxEmpty, trigHit;
  logic       txHold, rxHold, txLvl1, rxLvl1;
  logic [CW-1:0] cap;

  assign wrOn   = ctrlWrEn && ctrlWrData[0];
  assign enFlip = ctrlWrEn && (ctrlWrData[0] != fifoEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEn  <= 1'b0;
      dmaSel  <= 1'b0;
      trigSel <= 2'b00;
    end else if (ctrlWrEn) begin
      fifoEn <= ctrlWrData[0];
      if (wrOn) begin
        trigSel <= ctrlWrData[7:6];
        dmaSel  <= ctrlWrData[3];
      end
    end
  end

  always_comb begin
    stb.txFlush = (wrOn && ctrlWrData[2]) || enFlip;
    stb.rxFlush = (wrOn && ctrlWrData[1]) || enFlip;
    stb.txPush  = txWrEn;
    stb.txPop   = txPopEn;
    stb.rxPush  = rxPushEn;
    stb.rxPop   = rxRdEn;
    stb.legacy  = !fifoEn;
  end

  assign ctrlRdData = {trigSel, 2'b00, dmaSel, 2'b00, fifoEn};

  assign cap     = fifoEn ? CW'(DEPTH) : CW'(1);
  assign txEmpty = txCount == '0;
  assign txFull  = txCount >= cap;
  assign rxEmpty = rxCount == '0;
  assign trigHit = rxCount >= CW'(trigLevel(trigSel));
  assign mode1   = fifoEn && dmaSel;

  assign rxTrigIrq = fifoEn ? trigHit : !rxEmpty;

  // Hysteresis levels for the second signalling mode
  assign txLvl1 = txFull ? 1'b1 : (txEmpty ? 1'b0 : txHold);
  assign rxLvl1 = rxEmpty ? 1'b1 : ((trigHit || rxTimeout) ? 1'b0 : rxHold);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= 1'b0;
      rxHold <= 1'b1;
    end else begin
      txHold <= txLvl1;
      rxHold <= rxLvl1;
    end
  end

  assign txRdyN = mode1 ? txLvl1 : !txEmpty;
  assign rxRdyN = mode1 ? rxLvl1 : rxEmpty;
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWrEn,
  input  logic [7:0]    ctrlWrData,
  output logic [7:0]    ctrlRdData,
  input  logic          txWrEn,
  input  logic [7:0]    txWrData,
  input  logic          txPopEn,
  output logic [7:0]    txPopData,
  output logic [CW-1:0] txCount,
  output logic          txOverrun,
  input  logic          rxPushEn,
  input  logic [7:0]    rxPushData,
  input  logic          rxRdEn,
  output logic [7:0]    rxRdData,
  output logic [CW-1:0] rxCount,
  output logic          rxOverrun,
  input  logic          rxTimeout,
  output logic          rxTrigIrq,
  output logic          txRdyN,
  output logic          rxRdyN
);
  fifoStrobes_t stb;

  uart_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .txWrEn(txWrEn), .txPopEn(txPopEn), .rxPushEn(rxPushEn), .rxRdEn(rxRdEn),
    .rxTimeout(rxTimeout), .txCount(txCount), .rxCount(rxCount), .stb(stb),
    .ctrlRdData(ctrlRdData), .rxTrigIrq(rxTrigIrq), .txRdyN(txRdyN),
    .rxRdyN(rxRdyN));

  uart_fifo_dp #(.DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .txWrData(txWrData),
    .rxPushData(rxPushData), .txPopData(txPopData), .rxRdData(rxRdData),
    .txCount(txCount), .rxCount(rxCount), .txOverrun(txOverrun),
    .rxOverrun(rxOverrun));
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          ctrlWrEn,
  input logic [5:0]    wrFields,   // {write bits 7:6, write bits 3:0}
  input logic [7:0]    ctrlRdData,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input logic          rxOverrun,
  input logic          txRdyN,
  input logic          rxRdyN
);
  logic mode1;
  assign mode1 = ctrlRdData[0] && ctrlRdData[3];

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[5:4] == 2'b00 && ctrlRdData[2:1] == 2'b00); // R2
  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && wrFields[0]) |=> (ctrlRdData[7:6] == $past(wrFields[5:4]) && ctrlRdData[3] == $past(wrFields[3]))); // R2
  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && wrFields[0] && wrFields[2]) |=> txCount == '0); // R3
  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && wrFields[0] && wrFields[1]) |=> rxCount == '0); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CW'(DEPTH) && rxCount <= CW'(DEPTH)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !ctrlWrEn) |=> rxOverrun); // R7
  AST_LEGACY_CAP: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdData[0] |-> (txCount <= CW'(1) && rxCount <= CW'(1))); // R9
  AST_MODE0_RX: assert property (@(posedge clk) disable iff (!rstN)
    !mode1 |-> (rxRdyN == (rxCount == '0))); // R11
  AST_MODE1_TXFULL: assert property (@(posedge clk) disable iff (!rstN)
    (mode1 && txCount == CW'(DEPTH)) |-> txRdyN); // R12
  AST_MODE1_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (mode1 && rxCount == '0) |-> rxRdyN); // R13
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn),
  .wrFields({ctrlWrData[7:6], ctrlWrData[3:0]}), .ctrlRdData(ctrlRdData),
  .txCount(txCount), .rxCount(rxCount), .rxOverrun(rxOverrun),
  .txRdyN(txRdyN), .rxRdyN(rxRdyN));

// File: tb/test_uart_fifo_ctl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic [7:0] ctrlRdData;
  logic       txWrEn = 1'b0;
  logic [7:0] txWrData = '0;
  logic       txPopEn = 1'b0;
  logic [7:0] txPopData;
  logic [4:0] txCount;
  logic       txOverrun;
  logic       rxPushEn = 1'b0;
  logic [7:0] rxPushData = '0;
  logic       rxRdEn = 1'b0;
  logic [7:0] rxRdData;
  logic [4:0] rxCount;
  logic       rxOverrun;
  logic       rxTimeout = 1'b0;
  logic       rxTrigIrq, txRdyN, rxRdyN;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    ctrlWrEn = 1'b1; ctrlWrData = d; step(); ctrlWrEn = 1'b0;
  endtask
  task automatic pushRx(input logic [7:0] d);
    rxPushEn = 1'b1; rxPushData = d; step(); rxPushEn = 1'b0;
  endtask
  task automatic popRx();
    rxRdEn = 1'b1; step(); rxRdEn = 1'b0;
  endtask
  task automatic pushTx(input logic [7:0] d);
    txWrEn = 1'b1; txWrData = d; step(); txWrEn = 1'b0;
  endtask
  task automatic popTx();
    txPopEn = 1'b1; step(); txPopEn = 1'b0;
  endtask

  function automatic int lvlOf(input int t);
    return (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 ctrl", int'(ctrlRdData), 0);
    chk("R1 txCount", int'(txCount), 0);
    chk("R1 rxCount", int'(rxCount), 0);
    chk("R1 txRdyN", int'(txRdyN), 0);
    chk("R1 rxRdyN", int'(rxRdyN), 1);
    chk("R1 irq", int'(rxTrigIrq), 0);

    // R9 legacy single-byte holding
    pushRx(8'hA5);
    chk("R9 rxCount", int'(rxCount), 1);
    chk("R11 rxRdyN held", int'(rxRdyN), 0);
    chk("R10 legacy irq", int'(rxTrigIrq), 1);
    pushRx(8'h3C);
    chk("R9 second dropped", int'(rxCount), 1);
    chk("R7 legacy overrun", int'(rxOverrun), 1);
    popRx();
    chk("R9 data", int'(rxRdData), 'hA5);
    chk("R11 rxRdyN empty", int'(rxRdyN), 1);
    chk("R10 legacy irq off", int'(rxTrigIrq), 0);
    popRx();
    chk("R8 empty pop", int'(rxRdData), 'hA5);
    pushTx(8'h11);
    chk("R11 txRdyN loaded", int'(txRdyN), 1);
    chk("R9 txCount", int'(txCount), 1);

    // R5 enable change flushes
    wrCtrl(8'h01);
    chk("R5 txCount", int'(txCount), 0);
    chk("R5 rxOverrun", int'(rxOverrun), 0);
    chk("R2 ctrl 01", int'(ctrlRdData), 'h01);
    chk("R11 txRdyN empty", int'(txRdyN), 0);

    // R2 field load and gating
    wrCtrl(8'hCF);
    chk("R2 ctrl CF", int'(ctrlRdData), 'hC9);
    wrCtrl(8'h48);
    chk("R2 ctrl gated", int'(ctrlRdData), 'hC8);
    wrCtrl(8'h01);
    chk("R2 ctrl back", int'(ctrlRdData), 'h01);

    // R6 R7 R8 R10 trigger sweep
    for (int t = 0; t < 4; t++) begin
      wrCtrl({t[1:0], 6'b000011});
      chk("R4 flush count", int'(rxCount), 0);
      chk("R4 flush overrun", int'(rxOverrun), 0);
      for (int k = 0; k < 16; k++) begin
        pushRx(8'(k * 7 + t));
        chk("R6 count", int'(rxCount), k + 1);
        chk("R10 irq", int'(rxTrigIrq), int'((k + 1) >= lvlOf(t)));
      end
      pushRx(8'hEE);
      chk("R7 full count", int'(rxCount), 16);
      chk("R7 overrun", int'(rxOverrun), 1);
      for (int k = 0; k < 16; k++) begin
        popRx();
        chk("R6 order", int'(rxRdData), (k * 7 + t) & 255);
      end
      popRx();
      chk("R8 hold", int'(rxRdData), (15 * 7 + t) & 255);
      chk("R10 irq drained", int'(rxTrigIrq), 0);
    end

    // R3 transmit flush, mode 0
    wrCtrl(8'h07);
    pushRx(8'h55);
    for (int k = 0; k < 3; k++) begin
      pushTx(8'(k + 'h20));
      chk("R11 txRdyN", int'(txRdyN), 1);
    end
    popTx();
    chk("R6 tx order", int'(txPopData), 'h20);
    wrCtrl(8'h05);
    chk("R3 txCount", int'(txCount), 0);
    chk("R3 rx untouched", int'(rxCount), 1);
    chk("R11 txRdyN flushed", int'(txRdyN), 0);

    // R12 mode 1 transmit hysteresis
    wrCtrl(8'h0F);
    for (int k = 0; k < 16; k++) begin
      pushTx(8'(k));
      chk("R12 fill", int'(txRdyN), int'(k == 15));
    end
    for (int j = 0; j < 16; j++) begin
      popTx();
      chk("R12 drain", int'(txRdyN), int'((15 - j) != 0));
      chk("R6 tx data", int'(txPopData), j);
    end

    // R13 mode 1 receive, trigger 8
    wrCtrl(8'h8B);
    chk("R13 idle", int'(rxRdyN), 1);
    for (int k = 0; k < 12; k++) begin
      pushRx(8'(k));
      chk("R13 fill", int'(rxRdyN), int'((k + 1) < 8));
    end
    for (int j = 0; j < 12; j++) begin
      popRx();
      chk("R13 drain", int'(rxRdyN), int'((11 - j) == 0));
    end
    pushRx(8'h01);
    pushRx(8'h02);
    chk("R13 below trig", int'(rxRdyN), 1);
    rxTimeout = 1'b1; step(); rxTimeout = 1'b0;
    chk("R13 timeout", int'(rxRdyN), 0);
    popRx();
    chk("R13 still low", int'(rxRdyN), 0);
    popRx();
    chk("R13 empty", int'(rxRdyN), 1);

    // R4 / R3 flush and push in the same cycle
    wrCtrl(8'h01);
    for (int k = 0; k < 3; k++) pushRx(8'(k));
    rxPushEn = 1'b1; rxPushData = 8'h77;
    wrCtrl(8'h03);
    rxPushEn = 1'b0;
    chk("R4 flush wins", int'(rxCount), 0);
    pushRx(8'h42);
    pushTx(8'h10);
    txWrEn = 1'b1; txWrData = 8'h99;
    wrCtrl(8'h05);
    txWrEn = 1'b0;
    chk("R3 flush wins", int'(txCount), 0);
    chk("R3 rx kept", int'(rxCount), 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule